// File: doc/BRIEF.md
# PHY Status Aggregator with Cross-Register Latch Clearing

This block assembles a 16-bit read-only status word for an Ethernet PHY management space. Some of its bits follow live level signals from the PHY datapath. The rest are sticky flags that capture single-cycle event pulses and hold them until software reads them.

The sticky flags are shared with other registers in the management map. Each flag is cleared by a read of a different companion register, and never by a read of the aggregate word itself. The block therefore also serves the mirror bits of those companion registers. Every other bit of a companion register, and every other address, reads zero here; those contents belong to other logic.

A read is a one-cycle strobe carrying an address. The read data is registered: it appears on the cycle after the strobe and holds until the next strobe. It shows the flags as they stood before any clear caused by that same read.

Top module: `phy_status_agg`

## Requirements
- R1: After reset every sticky flag is 0 and the read data is 0. Bit 15 of the aggregate word (address 0x10) always reads 0.
- R2: In the aggregate word the live bits are: bit 14 crossover active (1 = pairs swapped), bit 10 signal detect, bit 9 descrambler lock, bit 5 jabber, bit 4 auto-negotiation complete, bit 3 loopback, bit 2 full duplex, bit 1 10 Mb/s mode (0 = 100 Mb/s), bit 0 link valid. Each reflects its input in the cycle of the read strobe.
- R3: The sticky bits of the aggregate word are: bit 13 receive error, bit 12 inverted polarity, bit 11 false carrier, bit 8 page received, bit 7 interrupt pending, bit 6 remote fault. A one-cycle pulse on an event input sets its flag, and the flag then holds until it is cleared.
- R4: A read of 0x15 clears only the receive-error flag. A read of 0x1A clears only polarity. A read of 0x14 clears only false carrier. A read of 0x06 clears only page received. A read of 0x12 clears only interrupt pending. A read of 0x01 clears only remote fault.
- R5: A read of the aggregate word (0x10) clears no flag.
- R6: The companion mirrors are: 0x1A bit 4 = polarity flag; 0x06 bit 1 = page flag; 0x12 bit 0 = interrupt flag; 0x01 bit 4 = remote-fault flag, bit 2 = link, bit 1 = jabber. All other bits of those words read 0. Addresses 0x14, 0x15 and every unlisted address read all zeros.
- R7: The read data changes only on the cycle after a read strobe. It carries the flag values held before that read's clear takes effect.
- R8: When an event pulse coincides with the read that clears its flag, the flag stays set. The read returns the previous flag value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | 5 | Register address of the read |
| ev_rx_err | input | 1 | Receive-error event pulse |
| ev_pol_inv | input | 1 | Inverted-polarity event pulse |
| ev_false_carrier | input | 1 | False-carrier event pulse |
| ev_page_rcvd | input | 1 | Page-received event pulse |
| ev_irq | input | 1 | Interrupt-pending event pulse |
| ev_remote_fault | input | 1 | Remote-fault notification pulse |
| lv_xover | input | 1 | Crossover active level |
| lv_sig_det | input | 1 | 100BASE-TX signal detect level |
| lv_descr_lock | input | 1 | 100BASE-TX descrambler lock level |
| lv_jabber | input | 1 | Jabber level |
| lv_an_done | input | 1 | Auto-negotiation complete level |
| lv_loopback | input | 1 | Loopback enabled level |
| lv_full_dup | input | 1 | Full duplex level |
| lv_speed10 | input | 1 | 10 Mb/s mode level |
| lv_link | input | 1 | Link valid level |
| rd_data | output | 16 | Registered read data |

## Verification
The bench targets a read of the aggregate word while flags are set. A design that cleared on that read would lose the flags before software reaches the owning register. It also drives an event pulse in the same cycle as the clearing read. If the clear won there, an event would be lost; if the read returned the post-clear value, an event would be reported twice or never. It checks that each companion read clears only its own flag, which catches swapped clear decodes. It also checks that the mirror bits sit at their exact positions while every other bit reads zero. Random levels on every pin expose any swapped or stuck live bits in the aggregate word.

// File: rtl/phy_status_pkg.sv
package phy_status_pkg;
    localparam int ADDR_W    = 5;
    localparam int DATA_W    = 16;
    localparam int NUM_LATCH = 6;

    localparam logic [ADDR_W-1:0] A_BMSR    = 5'h01;
    localparam logic [ADDR_W-1:0] A_ANEXP   = 5'h06;
    localparam logic [ADDR_W-1:0] A_PSTAT   = 5'h10;
    localparam logic [ADDR_W-1:0] A_ISR     = 5'h12;
    localparam logic [ADDR_W-1:0] A_FCCNT   = 5'h14;
    localparam logic [ADDR_W-1:0] A_RXECNT  = 5'h15;
    localparam logic [ADDR_W-1:0] A_TENSTAT = 5'h1A;

    // latch slot indices
    localparam int L_RXERR = 0;
    localparam int L_FCAR  = 1;
    localparam int L_POL   = 2;
    localparam int L_PAGE  = 3;
    localparam int L_IRQ   = 4;
    localparam int L_RFLT  = 5;

    // owning register of each sticky flag
    function automatic logic [ADDR_W-1:0] clear_addr(input int idx);
        case (idx)
            L_RXERR: return A_RXECNT;
            L_FCAR:  return A_FCCNT;
            L_POL:   return A_TENSTAT;
            L_PAGE:  return A_ANEXP;
            L_IRQ:   return A_ISR;
            default: return A_BMSR;
        endcase
    endfunction

    typedef struct packed {
        logic xover;
        logic sig_det;
        logic descr_lock;
        logic jabber;
        logic an_done;
        logic loopback;
        logic full_dup;
        logic speed10;
        logic link;
    } level_t;
endpackage

// File: rtl/phy_sticky_bank.sv
module phy_sticky_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        // set has priority over a simultaneous clear
        bank_d.flag = set_i | (bank_q.flag & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign q_o = bank_q.flag;

    for (genvar i = 0; i < N; i++) begin : g_chk
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
        p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !set_i[i]) |=> !q_o[i]);
        p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[i] && !clr_i[i]) |=> $stable(q_o[i]));
    end
endmodule

// File: rtl/phy_status_mux.sv
module phy_status_mux
    import phy_status_pkg::*;
(
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [NUM_LATCH-1:0] lat_i,
    input  level_t               lvl_i,
    output logic [DATA_W-1:0]    word_o
);
    always_comb begin
        word_o = '0;
        case (addr_i)
            A_PSTAT: begin
                word_o[14] = lvl_i.xover;
                word_o[13] = lat_i[L_RXERR];
                word_o[12] = lat_i[L_POL];
                word_o[11] = lat_i[L_FCAR];
                word_o[10] = lvl_i.sig_det;
                word_o[9]  = lvl_i.descr_lock;
                word_o[8]  = lat_i[L_PAGE];
                word_o[7]  = lat_i[L_IRQ];
                word_o[6]  = lat_i[L_RFLT];
                word_o[5]  = lvl_i.jabber;
                word_o[4]  = lvl_i.an_done;
                word_o[3]  = lvl_i.loopback;
                word_o[2]  = lvl_i.full_dup;
                word_o[1]  = lvl_i.speed10;
                word_o[0]  = lvl_i.link;
            end
            A_TENSTAT: word_o[4] = lat_i[L_POL];
            A_ANEXP:   word_o[1] = lat_i[L_PAGE];
            A_ISR:     word_o[0] = lat_i[L_IRQ];
            A_BMSR: begin
                word_o[4] = lat_i[L_RFLT];
                word_o[2] = lvl_i.link;
                word_o[1] = lvl_i.jabber;
            end
            default: word_o = '0;
        endcase
    end

    always_comb begin
        a_reserved_r1: assert (!(addr_i == A_PSTAT && word_o[15]));
    end
endmodule

// File: rtl/phy_status_agg.sv
module phy_status_agg
    import phy_status_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              ev_rx_err,
    input  logic              ev_pol_inv,
    input  logic              ev_false_carrier,
    input  logic              ev_page_rcvd,
    input  logic              ev_irq,
    input  logic              ev_remote_fault,
    input  logic              lv_xover,
    input  logic              lv_sig_det,
    input  logic              lv_descr_lock,
    input  logic              lv_jabber,
    input  logic              lv_an_done,
    input  logic              lv_loopback,
    input  logic              lv_full_dup,
    input  logic              lv_speed10,
    input  logic              lv_link,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } out_t;

    logic [NUM_LATCH-1:0] ev_set, rd_clr, lat_q;
    logic [DATA_W-1:0]    word;
    level_t               lvl;
    out_t                 out_d, out_q;

    assign ev_set[L_RXERR] = ev_rx_err;
    assign ev_set[L_FCAR]  = ev_false_carrier;
    assign ev_set[L_POL]   = ev_pol_inv;
    assign ev_set[L_PAGE]  = ev_page_rcvd;
    assign ev_set[L_IRQ]   = ev_irq;
    assign ev_set[L_RFLT]  = ev_remote_fault;

    for (genvar i = 0; i < NUM_LATCH; i++) begin : g_clr
        assign rd_clr[i] = rd_en && (rd_addr == clear_addr(i));
    end

    assign lvl = '{xover: lv_xover, sig_det: lv_sig_det, descr_lock: lv_descr_lock,
                   jabber: lv_jabber, an_done: lv_an_done, loopback: lv_loopback,
                   full_dup: lv_full_dup, speed10: lv_speed10, link: lv_link};

    phy_sticky_bank #(.N(NUM_LATCH)) u_bank (
        .clk(clk), .rst_n(rst_n), .set_i(ev_set), .clr_i(rd_clr), .q_o(lat_q)
    );

    phy_status_mux u_mux (
        .addr_i(rd_addr), .lat_i(lat_q), .lvl_i(lvl), .word_o(word)
    );

    always_comb begin
        out_d = out_q;
        if (rd_en) out_d.rdata = word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data = out_q.rdata;

    p_reserved_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[15]);
    p_status_noclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_PSTAT) |=> ((lat_q & $past(lat_q)) == $past(lat_q)));
    p_preclear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_RXECNT && !ev_rx_err) |=> !lat_q[L_RXERR]);
    p_pstat_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == A_PSTAT) |=> rd_data[13] == $past(lat_q[L_RXERR]));
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: tb/phy_status_agg_test.sv
`timescale 1ns/100ps
module phy_status_agg_test;
    logic clk = 0, rst_n = 0, rd_en = 0;
    logic [4:0] rd_addr = '0;
    logic [5:0] ev = '0;   // 0 rxerr,1 pol,2 fcar,3 page,4 irq,5 rflt
    logic [8:0] lv = '0;   // 8 xover,7 sig,6 descr,5 jab,4 an,3 lb,2 fd,1 s10,0 link
    logic [15:0] rd_data;
    logic [5:0] m = '0;    // bench model of the flags
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    phy_status_agg uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .ev_rx_err(ev[0]), .ev_pol_inv(ev[1]), .ev_false_carrier(ev[2]),
        .ev_page_rcvd(ev[3]), .ev_irq(ev[4]), .ev_remote_fault(ev[5]),
        .lv_xover(lv[8]), .lv_sig_det(lv[7]), .lv_descr_lock(lv[6]),
        .lv_jabber(lv[5]), .lv_an_done(lv[4]), .lv_loopback(lv[3]),
        .lv_full_dup(lv[2]), .lv_speed10(lv[1]), .lv_link(lv[0]),
        .rd_data(rd_data)
    );

    function automatic logic [15:0] exp_word(logic [4:0] a, logic [5:0] f, logic [8:0] l);
        logic [15:0] w = '0;
        if (a == 5'h10) begin
            w = {1'b0, l[8], f[0], f[1], f[2], l[7], l[6], f[3], f[4], f[5], l[5:0]};
        end else if (a == 5'h1A) w[4] = f[1];
        else if (a == 5'h06) w[1] = f[3];
        else if (a == 5'h12) w[0] = f[4];
        else if (a == 5'h01) begin w[4] = f[5]; w[2] = l[0]; w[1] = l[5]; end
        return w;
    endfunction

    function automatic logic [5:0] clr_of(logic en, logic [4:0] a);
        logic [5:0] c = '0;
        if (en) begin
            c[0] = (a == 5'h15); c[1] = (a == 5'h1A); c[2] = (a == 5'h14);
            c[3] = (a == 5'h06); c[4] = (a == 5'h12); c[5] = (a == 5'h01);
        end
        return c;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // called at negedge; one clock; returns at next negedge and checks
    task automatic step(logic en, logic [4:0] a, logic [5:0] e, logic [8:0] l, string tag);
        logic [15:0] exp = rd_data;
        rd_en = en; rd_addr = a; ev = e; lv = l;
        if (en) exp = exp_word(a, m, l);
        m = e | (m & ~clr_of(en, a));
        @(posedge clk); @(negedge clk);
        rd_en = 0; ev = '0;
        check(tag, rd_data, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset data", rd_data, 16'h0000);
        rst_n = 1;
        step(1, 5'h10, 6'h00, 9'h000, "R1 status after reset");
        step(1, 5'h10, 6'h00, 9'h1FF, "R1 R2 all levels high bit15 zero");
        // set all flags, then read status twice: nothing clears (R5)
        step(0, 5'h10, 6'h3F, 9'h000, "R7 hold without read");
        step(1, 5'h10, 6'h00, 9'h000, "R3 all flags set");
        step(1, 5'h10, 6'h00, 9'h000, "R5 status read keeps flags");
        // each companion read clears only its own flag (R4, R6)
        step(1, 5'h15, 6'h00, 9'h000, "R6 rx err counter reads zero");
        step(1, 5'h10, 6'h00, 9'h000, "R4 only rx err cleared");
        step(1, 5'h1A, 6'h00, 9'h000, "R6 polarity mirror");
        step(1, 5'h1A, 6'h00, 9'h000, "R4 polarity mirror cleared");
        step(1, 5'h01, 6'h00, 9'h021, "R6 basic status mirror");
        step(1, 5'h10, 6'h00, 9'h000, "R4 after basic status read");
        // event coincides with its clearing read (R8)
        step(1, 5'h06, 6'h08, 9'h000, "R8 read returns prior page flag");
        step(1, 5'h06, 6'h00, 9'h000, "R8 page flag survived clear");
        step(1, 5'h06, 6'h00, 9'h000, "R8 page flag now cleared");
        step(1, 5'h12, 6'h10, 9'h000, "R8 irq set during clear");
        step(1, 5'h10, 6'h00, 9'h000, "R8 irq still pending");
        // constrained random
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] a;
            logic [5:0] e;
            int sel = $urandom_range(0, 9);
            case (sel)
                0, 1, 2: a = 5'h10;
                3: a = 5'h15; 4: a = 5'h1A; 5: a = 5'h14;
                6: a = 5'h06; 7: a = 5'h12; 8: a = 5'h01;
                default: a = 5'($urandom);
            endcase
            e = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h00;
            step($urandom_range(0, 2) != 0, a, e, 9'($urandom),
                 (a == 5'h10) ? "R2 R3 R5 random status" : "R4 R6 R7 random companion");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule